// File: doc/BRIEF.md
# Infrared Pulse-Width Capture Unit

This block samples a demodulated infrared receiver line and records how long each mark (line low) and each space (line high) lasts, counted in programmable sample units. Widths are stored as saturating 8-bit counts, alternating mark and space, in a bank of 17 readable 32-bit words holding 68 byte-sized fields. A space that reaches the programmed end count closes the message. A full bank also closes it. In both cases capture freezes and a maskable interrupt is raised.

Software configures the unit through a small word-addressed register port. It sets the sample divider and end count, then turns on both capture enables. When the interrupt arrives, software reads the capture words, then issues a restart command and an interrupt-clear command. Protocol decoding is left to software.

Top module: `ir_width_capture`

## Requirements
- R1: Capture advances only while CTRL (address 0x00) has both bit0 (receive enable) and bit1 (width measurement enable) set. With either bit clear, line activity leaves the capture words at zero and sets no interrupt status.
- R2: The PERIOD register (address 0x01) holds a value P. One sample is taken every P+1 clock cycles, and every width is a count of samples.
- R3: Width number k (from 0) is stored in capture word k/4 at address 0x10+k/4, in bits [8*(k mod 4)+7 : 8*(k mod 4)]. There are 17 words and 68 fields, and field 0 holds the first width of the message.
- R4: Stored widths alternate strictly. Field 0 is always a mark (line low), field 1 a space, and so on. Idle space before the first mark is not stored.
- R5: A width count saturates at 255 and never wraps, so a mark of 255 samples or longer is stored as 255.
- R6: A space whose sample count reaches the ENDCNT value (address 0x02, usable range 2 to 255, reset value 255) completes the message. That field is stored as 255 and the interrupt status is set.
- R7: When all 68 fields have been written, capture stops and the interrupt status is set. Later edges are dropped and no terminating 255 is written.
- R8: After completion, and until a restart, line activity is ignored and the capture words keep their values.
- R9: Writing 1 to bit0 of CMD (address 0x03) clears every capture word and returns capture to idle, waiting for a mark.
- R10: The interrupt status is STATUS (address 0x04) bit0. Output irq equals the status ANDed with CTRL bit2. Writing 1 to CMD bit1 clears the status, but a completion in the same cycle wins and leaves it set.
- R11: After reset, CTRL and PERIOD read 0, ENDCNT reads 255, STATUS and every capture word read 0, and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_in | input | 1 | Demodulated infrared line, asynchronous, low means mark |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 6 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational from bus_addr |
| irq | output | 1 | Interrupt request, level |

## Verification
A message can complete in the same clock cycle that software writes the interrupt-clear bit. Because the arrival of the terminating space is set, this collision is the one most likely to lose an interrupt. The bench runs at one sample per clock and counts, register by register, the cycle on which a short terminating space sets the status, then puts the clear write on exactly that edge. The status must remain set. A second run places the clear one cycle later, and there the status must read zero.

// File: rtl/ir_cap_pkg.sv
package ir_cap_pkg;
  localparam int WID_W     = 8;
  localparam int FLD_PER_W = 4;

  localparam int A_CTRL   = 0;
  localparam int A_PERIOD = 1;
  localparam int A_ENDCNT = 2;
  localparam int A_CMD    = 3;
  localparam int A_STATUS = 4;
  localparam int A_CAP    = 16;

  typedef enum logic [2:0] {
    CS_IDLE  = 3'd0,
    CS_MARK  = 3'd1,
    CS_SPACE = 3'd2,
    CS_DONE  = 3'd3,
    CS_FULL  = 3'd4
  } cap_state_t;
endpackage

// File: rtl/ir_cap_sync.sv
module ir_cap_sync #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      q_sync <= RST_VAL;
    end else begin
      meta_q <= d_async;
      q_sync <= meta_q;
    end
  end
endmodule

// File: rtl/ir_cap_tick.sv
module ir_cap_tick #(
  parameter int PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic [PERIOD_W-1:0] period,
  output logic                tick
);
  logic [PERIOD_W-1:0] cnt_q, cnt_d;

  assign tick = en && (cnt_q >= period);

  always_comb begin
    if (!en || tick) cnt_d = '0;
    else             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/ir_cap_core.sv
module ir_cap_core
  import ir_cap_pkg::*;
#(
  parameter int WORDS = 17,
  localparam int SLOTS = WORDS * FLD_PER_W,
  localparam int IDX_W = $clog2(SLOTS + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tick,
  input  logic                   mark_lvl,
  input  logic                   restart,
  input  logic [WID_W-1:0]       end_cnt,
  output logic [SLOTS*WID_W-1:0] bank_flat,
  output logic                   done_pulse,
  output cap_state_t             state_o,
  output logic [IDX_W-1:0]       idx_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SLOTS - 1);
  localparam logic [WID_W-1:0] SAT_V    = '1;
  localparam logic [WID_W-1:0] ONE_V    = WID_W'(1);

  cap_state_t       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [WID_W-1:0] cnt_q, cnt_d, cnt_inc, st_val;
  logic             st_wr;

  assign cnt_inc = (cnt_q == SAT_V) ? SAT_V : cnt_q + 1'b1;

  always_comb begin
    state_d    = state_q;
    idx_d      = idx_q;
    cnt_d      = cnt_q;
    st_wr      = 1'b0;
    st_val     = cnt_q;
    done_pulse = 1'b0;
    if (restart) begin
      state_d = CS_IDLE;
      idx_d   = '0;
      cnt_d   = '0;
    end else if (tick) begin
      unique case (state_q)
        CS_IDLE: begin
          if (mark_lvl) begin
            state_d = CS_MARK;
            cnt_d   = ONE_V;
          end
        end
        CS_MARK: begin
          if (mark_lvl) begin
            cnt_d = cnt_inc;
          end else begin
            st_wr = 1'b1;
            idx_d = idx_q + 1'b1;
            cnt_d = ONE_V;
            if (idx_q == LAST_IDX) begin
              state_d    = CS_FULL;
              done_pulse = 1'b1;
            end else begin
              state_d = CS_SPACE;
            end
          end
        end
        CS_SPACE: begin
          if (mark_lvl) begin
            st_wr = 1'b1;
            idx_d = idx_q + 1'b1;
            cnt_d = ONE_V;
            if (idx_q == LAST_IDX) begin
              state_d    = CS_FULL;
              done_pulse = 1'b1;
            end else begin
              state_d = CS_MARK;
            end
          end else if (cnt_inc >= end_cnt) begin
            st_wr      = 1'b1;
            st_val     = SAT_V;
            idx_d      = idx_q + 1'b1;
            state_d    = CS_DONE;
            done_pulse = 1'b1;
          end else begin
            cnt_d = cnt_inc;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CS_IDLE;
      idx_q   <= '0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      cnt_q   <= cnt_d;
    end
  end

  for (genvar gi = 0; gi < SLOTS; gi++) begin : g_slot
    logic [WID_W-1:0] slot_q;
    logic             slot_we;

    assign slot_we = st_wr && (idx_q == IDX_W'(gi));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       slot_q <= '0;
      else if (restart) slot_q <= '0;
      else if (slot_we) slot_q <= st_val;
    end

    assign bank_flat[gi*WID_W +: WID_W] = slot_q;
  end

  assign state_o = state_q;
  assign idx_o   = idx_q;
endmodule

// File: rtl/ir_width_capture.sv
module ir_width_capture
  import ir_cap_pkg::*;
#(
  parameter int         PERIOD_W = 16,
  parameter int         WORDS    = 17,
  parameter int         ADDR_W   = 6,
  parameter logic [7:0] DEF_END  = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ir_in,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq
);
  localparam int SLOTS = WORDS * FLD_PER_W;
  localparam int IDX_W = $clog2(SLOTS + 1);
  localparam int WORD_BITS = WID_W * FLD_PER_W;
  localparam logic [ADDR_W-1:0] AD_CTRL   = ADDR_W'(A_CTRL);
  localparam logic [ADDR_W-1:0] AD_PERIOD = ADDR_W'(A_PERIOD);
  localparam logic [ADDR_W-1:0] AD_ENDCNT = ADDR_W'(A_ENDCNT);
  localparam logic [ADDR_W-1:0] AD_CMD    = ADDR_W'(A_CMD);
  localparam logic [ADDR_W-1:0] AD_STATUS = ADDR_W'(A_STATUS);

  logic [2:0]             ctrl_q, ctrl_d;
  logic [PERIOD_W-1:0]    period_q, period_d;
  logic [WID_W-1:0]       endcnt_q, endcnt_d;
  logic                   pend_q, pend_d;
  logic                   restart_cmd, clr_cmd, cap_en, tick;
  logic                   ir_s, done_pulse;
  logic [SLOTS*WID_W-1:0] bank_flat;
  cap_state_t             cap_state;
  logic [IDX_W-1:0]       cap_idx;
  logic                   unused_wdata;

  assign unused_wdata = ^bus_wdata[31:PERIOD_W];

  ir_cap_sync #(.RST_VAL(1'b1)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_async(ir_in),
    .q_sync (ir_s)
  );

  assign cap_en = ctrl_q[0] & ctrl_q[1];

  ir_cap_tick #(.PERIOD_W(PERIOD_W)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (cap_en),
    .period(period_q),
    .tick  (tick)
  );

  ir_cap_core #(.WORDS(WORDS)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .mark_lvl  (~ir_s),
    .restart   (restart_cmd),
    .end_cnt   (endcnt_q),
    .bank_flat (bank_flat),
    .done_pulse(done_pulse),
    .state_o   (cap_state),
    .idx_o     (cap_idx)
  );

  assign restart_cmd = bus_wr && (bus_addr == AD_CMD) && bus_wdata[0];
  assign clr_cmd     = bus_wr && (bus_addr == AD_CMD) && bus_wdata[1];

  always_comb begin
    ctrl_d   = ctrl_q;
    period_d = period_q;
    endcnt_d = endcnt_q;
    if (bus_wr && bus_addr == AD_CTRL)   ctrl_d   = bus_wdata[2:0];
    if (bus_wr && bus_addr == AD_PERIOD) period_d = bus_wdata[PERIOD_W-1:0];
    if (bus_wr && bus_addr == AD_ENDCNT) endcnt_d = bus_wdata[WID_W-1:0];
    if (done_pulse)   pend_d = 1'b1;
    else if (clr_cmd) pend_d = 1'b0;
    else              pend_d = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      period_q <= '0;
      endcnt_q <= DEF_END;
      pend_q   <= 1'b0;
    end else begin
      ctrl_q   <= ctrl_d;
      period_q <= period_d;
      endcnt_q <= endcnt_d;
      pend_q   <= pend_d;
    end
  end

  assign irq = pend_q & ctrl_q[2];

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == AD_CTRL) begin
      bus_rdata[2:0] = ctrl_q;
    end else if (bus_addr == AD_PERIOD) begin
      bus_rdata[PERIOD_W-1:0] = period_q;
    end else if (bus_addr == AD_ENDCNT) begin
      bus_rdata[WID_W-1:0] = endcnt_q;
    end else if (bus_addr == AD_STATUS) begin
      bus_rdata[0] = pend_q;
    end else begin
      for (int w = 0; w < WORDS; w++) begin
        if (bus_addr == ADDR_W'(A_CAP + w))
          bus_rdata = bank_flat[w*WORD_BITS +: WORD_BITS];
      end
    end
  end
endmodule

// File: rtl/ir_cap_checker.sv
module ir_cap_checker
  import ir_cap_pkg::*;
#(
  parameter int SLOTS = 68,
  parameter int IDX_W = 7
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cap_en,
  input logic                   restart_cmd,
  input logic                   clr_cmd,
  input logic                   done_pulse,
  input logic                   pend,
  input cap_state_t             state,
  input logic [IDX_W-1:0]       idx,
  input logic [SLOTS*WID_W-1:0] bank
);
  AST_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_en && !restart_cmd) |=> $stable(state)); // R1

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= IDX_W'(SLOTS)); // R7

  AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (state == CS_DONE && !restart_cmd) |=> $stable(bank)); // R8

  AST_RESTART_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    restart_cmd |=> (state == CS_IDLE && idx == '0)); // R9

  AST_PEND_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> (state == CS_DONE || state == CS_FULL)); // R10

  AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_cmd && !done_pulse) |=> !pend); // R10
endmodule

bind ir_width_capture ir_cap_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cap_en     (cap_en),
  .restart_cmd(restart_cmd),
  .clr_cmd    (clr_cmd),
  .done_pulse (done_pulse),
  .pend       (pend_q),
  .state      (cap_state),
  .idx        (cap_idx),
  .bank       (bank_flat)
);

// File: tb/tb_ir_width_capture.sv
`timescale 1ns/1ps
module tb_ir_width_capture;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ir_in;
  logic        bus_wr;
  logic [5:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  int msg[80];
  int msg_n;
  int cur_p;
  int cur_end;
  int exp_b[68];

  always #4 clk = ~clk;

  ir_width_capture dut (
    .clk(clk), .rst_n(rst_n), .ir_in(ir_in), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 6'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = 6'(a);
    #1 v = bus_rdata;
  endtask

  task automatic build_expect();
    for (int k = 0; k < 68; k++) begin
      if (k < msg_n)       exp_b[k] = (msg[k] > 255) ? 255 : msg[k];
      else if (k == msg_n) exp_b[k] = 255;
      else                 exp_b[k] = 0;
    end
  endtask

  task automatic check_bank(input string req);
    for (int w = 0; w < 17; w++) begin
      logic [31:0] e;
      logic [31:0] a;
      for (int b = 0; b < 4; b++) e[b*8 +: 8] = 8'(exp_b[w*4+b]);
      rd(16 + w, a);
      chk(req, a, e);
    end
  endtask

  task automatic check_zero(input string req);
    for (int k = 0; k < 68; k++) exp_b[k] = 0;
    check_bank(req);
  endtask

  task automatic send();
    for (int i = 0; i < msg_n; i++) begin
      ir_in = (i % 2 == 0) ? 1'b0 : 1'b1;
      repeat (msg[i] * (cur_p + 1)) @(negedge clk);
    end
    ir_in = 1'b1;
    repeat ((cur_end + 6) * (cur_p + 1)) @(negedge clk);
  endtask

  task automatic restart_all();
    wr(3, 32'h3);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    int base[9];
    base = '{3, 1, 5, 2, 7, 4, 1, 11, 2};
    rst_n = 1'b0; ir_in = 1'b1; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    rd(0, v); chk("R11 ctrl", v, 32'h0);
    rd(1, v); chk("R11 period", v, 32'h0);
    rd(2, v); chk("R11 endcnt", v, 32'd255);
    rd(4, v); chk("R11 status", v, 32'h0);
    chk("R11 irq", {31'h0, irq}, 32'h0);
    check_zero("R11 words");

    // R1 gating: one enable missing at a time
    cur_p = 0; cur_end = 12;
    wr(2, 12);
    msg_n = 3; msg[0] = 4; msg[1] = 2; msg[2] = 5;
    wr(0, 32'h5); send();
    rd(4, v); chk("R1 rx only status", v, 32'h0);
    check_zero("R1 rx only words");
    wr(0, 32'h6); send();
    rd(4, v); chk("R1 meas only status", v, 32'h0);
    check_zero("R1 meas only words");

    // R2 R3 R4 R6 R9 R10 sweep over sample periods
    for (int p = 0; p < 4; p++) begin
      restart_all();
      wr(0, 32'h0);
      cur_p = p;
      wr(1, p);
      wr(0, 32'h7);
      msg_n = 9;
      for (int i = 0; i < 9; i++) msg[i] = base[(i + p) % 9];
      send();
      build_expect();
      check_bank("R2 R3 R4 R6 sweep");
      rd(4, v); chk("R6 status after end", v, 32'h1);
      chk("R10 irq enabled", {31'h0, irq}, 32'h1);
      wr(3, 32'h2);
      rd(4, v); chk("R10 status cleared", v, 32'h0);
      chk("R10 irq cleared", {31'h0, irq}, 32'h0);
      wr(3, 32'h1);
      check_zero("R9 restart clears");
    end

    // R3 R6 boundary: terminator lands in the last field
    restart_all();
    cur_p = 1; wr(1, 1);
    msg_n = 67;
    for (int i = 0; i < 67; i++) msg[i] = (i % 5) + 1;
    send();
    build_expect();
    check_bank("R3 R6 last field");
    rd(4, v); chk("R6 status last field", v, 32'h1);

    // R5 saturation, default end count
    restart_all();
    cur_p = 0; wr(1, 0);
    cur_end = 255; wr(2, 255);
    msg_n = 5; msg[0] = 300; msg[1] = 4; msg[2] = 255; msg[3] = 2; msg[4] = 256;
    send();
    build_expect();
    check_bank("R5 saturation");

    // R8 frozen after completion
    ir_in = 1'b0; repeat (10) @(negedge clk);
    ir_in = 1'b1; repeat (5) @(negedge clk);
    ir_in = 1'b0; repeat (7) @(negedge clk);
    ir_in = 1'b1; repeat (300) @(negedge clk);
    check_bank("R8 words frozen");
    rd(4, v); chk("R8 status held", v, 32'h1);

    // R10 mask
    wr(0, 32'h3);
    chk("R10 irq masked", {31'h0, irq}, 32'h0);
    rd(4, v); chk("R10 status while masked", v, 32'h1);
    wr(0, 32'h7);
    chk("R10 irq unmasked", {31'h0, irq}, 32'h1);

    // R7 overflow
    restart_all();
    cur_end = 255;
    msg_n = 70;
    for (int i = 0; i < 70; i++) msg[i] = 3;
    send();
    build_expect();
    check_bank("R7 overflow");
    rd(4, v); chk("R7 status on full", v, 32'h1);

    // R10 completion and clear on the same edge: set wins
    restart_all();
    cur_end = 4; wr(2, 4);
    @(negedge clk);
    ir_in = 1'b0; repeat (3) @(negedge clk);
    ir_in = 1'b1;
    repeat (5) @(negedge clk);
    bus_wr = 1'b1; bus_addr = 6'd3; bus_wdata = 32'h2;
    @(negedge clk);
    bus_wr = 1'b0;
    rd(4, v); chk("R10 set wins over clear", v, 32'h1);
    msg_n = 1; msg[0] = 3; build_expect();
    check_bank("R6 short end count");

    // R10 clear one edge after completion
    restart_all();
    @(negedge clk);
    ir_in = 1'b0; repeat (3) @(negedge clk);
    ir_in = 1'b1;
    repeat (6) @(negedge clk);
    bus_wr = 1'b1; bus_addr = 6'd3; bus_wdata = 32'h2;
    @(negedge clk);
    bus_wr = 1'b0;
    rd(4, v); chk("R10 clear after set", v, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule